// File: doc/BRIEF.md
# Bipolar Serial Word Transmitter with Five-Word Queue

This block takes complete 32-bit words from a host, queues up to five of them, and sends them one after another as bipolar return-to-zero serial words on two output lines. One line pulses for a logic one and the other pulses for a logic zero. Both lines are low during the second half of every bit and between words. The host presents a word and a one-cycle `push` strobe. The host side that builds words from bytes, and the analogue line drivers, sit outside this block.

The transmitter takes the most significant bit of each word as a parity slot. Whatever the host put there is replaced with a parity bit. The parity sense is chosen by a level input, either odd or even. After every word the transmitter holds both lines low for at least a fixed number of bit times before it starts the next word.

The host sees a full flag and an empty flag for the queue. A sticky overflow flag records a push that was refused because the queue was full. An interrupt line reports that the last queued word has finished and nothing is left to send. The host is expected to space its word writes. A push may still arrive in any cycle, and the queue takes it whenever a slot is free.

Top module: `bipolar_word_tx`

## Requirements
- R1: After a synchronous active-low reset, `out_one` and `out_zero` are low, `q_empty` is 1, and `q_full`, `tx_irq` and `ovf_flag` are 0.
- R2: Bits go out in order from `push_word[0]` up to `push_word[31]`. Each bit drives `out_one` (for a 1) or `out_zero` (for a 0) high for HALF_CLKS clocks, then holds both lines low for HALF_CLKS clocks. The two lines are never high together.
- R3: Transmitted bit 32 (word bit 31) is replaced. With `odd_parity`=1 the 32 transmitted bits hold an odd number of ones, and with `odd_parity`=0 an even number. `odd_parity` is sampled when the word leaves the queue.
- R4: The queue holds up to DEPTH (5) words, not counting the word being sent. Words are sent in push order. `q_full` is 1 exactly when DEPTH words wait, and `q_empty` is 1 exactly when none wait.
- R5: A push while `q_full`=1 is dropped: that word is never transmitted, and `ovf_flag` goes to 1 and stays 1 until reset.
- R6: Between the last bit of one word and the first bit of the next, both lines stay low for at least GAP_BITS (4) bit times.
- R7: `tx_irq` goes to 1 when a word's last bit time ends with the queue empty. It returns to 0 on an accepted push. If the push comes in that same cycle, `tx_irq` stays 0.
- R8: A push in the same cycle as the transmitter takes a word from a non-full queue is accepted.
- R9: From idle with an empty queue, the first bit appears on the lines in the second clock after the clock that samples `push`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push | input | 1 | One-cycle strobe that queues `push_word` |
| push_word | input | 32 | Word to queue; bit 0 is sent first, bit 31 is replaced by parity |
| odd_parity | input | 1 | 1 = odd parity, 0 = even parity |
| out_one | output | 1 | Pulses high in the first half of each 1 bit |
| out_zero | output | 1 | Pulses high in the first half of each 0 bit |
| q_full | output | 1 | Queue holds DEPTH waiting words |
| q_empty | output | 1 | No words waiting |
| tx_irq | output | 1 | Last word finished and the queue is empty |
| ovf_flag | output | 1 | Sticky: a push was refused |

## Verification
Two cases are tested where two events land in the same cycle.

The first is a push in the cycle the serializer takes a word from the queue. A back-to-back burst provokes it, and the bench judges it by `q_empty` staying 0 and by both words arriving on the lines in order.

The second is a push in the exact cycle the final bit time of the last word ends. The bench times this from the first observed pulse. It judges the case by `tx_irq` staying 0 and by the interrupt rising only after the second word ends.

The same burst also overfills the queue. The bench shows the refused word never appears on the lines.

// File: rtl/bwt_pkg.sv
`timescale 1ns/1ps
// Package: types and helpers shared by the bipolar word transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package bwt_pkg;

    // Serializer states: waiting for a word, sending bits, holding the inter-word null
    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_BIT  = 2'd1,
        SER_GAP  = 2'd2
    } ser_state_t;

    // Bit value that gives the requested overall parity for a given xor of data bits
    function automatic logic parity_bit(input logic data_xor, input logic odd);
        return odd ? ~data_xor : data_xor;
    endfunction

endpackage

// File: rtl/bwt_queue.sv
`timescale 1ns/1ps
// Module: bwt_queue
// Circular word queue of DEPTH entries with single-cycle push and pop.
// Assumes: a push while full is dropped and reported on wr_drop for one cycle;
// a pop while empty is never requested (the serializer pops only on !empty).
module bwt_queue #(
    parameter int DEPTH = 5,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty,
    output logic         wr_drop,
    output logic         wr_ok
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          rd_ok;

    // Advance a pointer with wrap at the last entry
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign wr_ok   = wr_en && !full;
    assign wr_drop = wr_en && full;
    assign rd_ok   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    // Store an accepted word at the write pointer
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Maintain pointers and occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= bump(wr_ptr);
            if (rd_ok) rd_ptr <= bump(rd_ptr);
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/bwt_parity_fix.sv
`timescale 1ns/1ps
// Module: bwt_parity_fix
// Replaces the top bit of a word with a parity bit computed over the rest.
// Assumes: odd=1 asks for an odd number of ones across all W bits.
module bwt_parity_fix
    import bwt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] word_in,
    input  logic         odd,
    output logic [W-1:0] word_out
);
    localparam logic [W-1:0] DATA_MASK = {1'b0, {(W-1){1'b1}}};

    logic data_x;

    // Xor of the data bits only; the host's top bit is masked off
    always_comb begin
        data_x   = ^(word_in & DATA_MASK);
        word_out = (word_in & DATA_MASK) | {parity_bit(data_x, odd), {(W-1){1'b0}}};
    end

endmodule

// File: rtl/bwt_serializer.sv
`timescale 1ns/1ps
// Module: bwt_serializer
// Sends one word LSB first as bipolar return-to-zero bits, then holds a null gap.
// Assumes: 'avail' means a word waits at 'load_word'; 'take' pops it in the same cycle.
// Each bit lasts 2*HALF_CLKS clocks; the gap lasts GAP_BITS bit times, plus one idle clock.
module bwt_serializer
    import bwt_pkg::*;
#(
    parameter int W         = 32,
    parameter int HALF_CLKS = 4,
    parameter int GAP_BITS  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         avail,
    input  logic [W-1:0] load_word,
    output logic         take,
    output logic         line_one,
    output logic         line_zero,
    output logic         word_done
);
    localparam int GAP_CLKS = GAP_BITS * 2 * HALF_CLKS;
    localparam int HCW      = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam int GCW      = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;
    localparam int BW       = $clog2(W);

    ser_state_t     st;
    logic [HCW-1:0] half_cnt;
    logic           second;
    logic [BW-1:0]  bit_idx;
    logic [GCW-1:0] gap_cnt;
    logic [W-1:0]   sh;
    logic           half_end, last_bit, gap_end;

    // Decode counter end points and the pop strobe
    always_comb begin
        half_end  = (half_cnt == HCW'(HALF_CLKS - 1));
        last_bit  = (bit_idx == BW'(W - 1));
        gap_end   = (gap_cnt == GCW'(GAP_CLKS - 1));
        take      = (st == SER_IDLE) && avail;
        word_done = (st == SER_BIT) && half_end && second && last_bit;
    end

    // Drive the active line in the first half of each bit, null otherwise
    always_comb begin
        line_one  = (st == SER_BIT) && !second && sh[0];
        line_zero = (st == SER_BIT) && !second && !sh[0];
    end

    // Sequence load, bit halves, shifting and the inter-word gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SER_IDLE;
            half_cnt <= '0;
            second   <= 1'b0;
            bit_idx  <= '0;
            gap_cnt  <= '0;
            sh       <= '0;
        end else begin
            case (st)
                SER_IDLE: begin
                    if (avail) begin
                        st       <= SER_BIT;
                        sh       <= load_word;
                        half_cnt <= '0;
                        second   <= 1'b0;
                        bit_idx  <= '0;
                    end
                end
                SER_BIT: begin
                    if (half_end) begin
                        half_cnt <= '0;
                        second   <= ~second;
                        if (second) begin
                            sh <= {1'b0, sh[W-1:1]};
                            if (last_bit) begin
                                st      <= SER_GAP;
                                gap_cnt <= '0;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end else begin
                        half_cnt <= half_cnt + 1'b1;
                    end
                end
                SER_GAP: begin
                    if (gap_end) st <= SER_IDLE;
                    else         gap_cnt <= gap_cnt + 1'b1;
                end
                default: st <= SER_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bwt_flags.sv
`timescale 1ns/1ps
// Module: bwt_flags
// Holds the sticky overflow flag and the transmitter-done interrupt.
// Assumes: an accepted push clears the interrupt and wins over a set in the same cycle.
module bwt_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic push_ok,
    input  logic push_drop,
    input  logic word_done,
    input  logic q_empty,
    output logic irq,
    output logic ovf
);
    // Latch overflow until reset
    always_ff @(posedge clk) begin
        if (!rst_n)         ovf <= 1'b0;
        else if (push_drop) ovf <= 1'b1;
    end

    // Raise the interrupt when the last word ends; clear it on new work
    always_ff @(posedge clk) begin
        if (!rst_n)                     irq <= 1'b0;
        else if (push_ok)               irq <= 1'b0;
        else if (word_done && q_empty)  irq <= 1'b1;
    end

endmodule

// File: rtl/bipolar_word_tx.sv
`timescale 1ns/1ps
// Module: bipolar_word_tx (top)
// Five-word queue feeding a bipolar return-to-zero serializer, with automatic
// parity on the top bit, a fixed null gap between words, and status flags.
// Assumes: push is a one-cycle strobe per complete word; odd_parity is steady
// while words are queued (it is sampled as each word leaves the queue).
module bipolar_word_tx #(
    parameter int DEPTH     = 5,
    parameter int W         = 32,
    parameter int HALF_CLKS = 4,
    parameter int GAP_BITS  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_word,
    input  logic         odd_parity,
    output logic         out_one,
    output logic         out_zero,
    output logic         q_full,
    output logic         q_empty,
    output logic         tx_irq,
    output logic         ovf_flag
);
    logic [W-1:0] head_word, fixed_word;
    logic         deq, push_ok, push_drop, word_done;

    bwt_queue #(.DEPTH(DEPTH), .W(W)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_data (push_word),
        .rd_en   (deq),
        .rd_data (head_word),
        .full    (q_full),
        .empty   (q_empty),
        .wr_drop (push_drop),
        .wr_ok   (push_ok)
    );

    bwt_parity_fix #(.W(W)) u_par (
        .word_in  (head_word),
        .odd      (odd_parity),
        .word_out (fixed_word)
    );

    bwt_serializer #(.W(W), .HALF_CLKS(HALF_CLKS), .GAP_BITS(GAP_BITS)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .avail     (!q_empty),
        .load_word (fixed_word),
        .take      (deq),
        .line_one  (out_one),
        .line_zero (out_zero),
        .word_done (word_done)
    );

    bwt_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_ok   (push_ok),
        .push_drop (push_drop),
        .word_done (word_done),
        .q_empty   (q_empty),
        .irq       (tx_irq),
        .ovf       (ovf_flag)
    );

endmodule

// File: rtl/bipolar_word_tx_chk.sv
`timescale 1ns/1ps
// Module: bipolar_word_tx_chk
// Property checks for the transmitter, bound into every instance of the top.
module bipolar_word_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic push,
    input logic out_one,
    input logic out_zero,
    input logic q_full,
    input logic q_empty,
    input logic tx_irq,
    input logic ovf_flag,
    input logic deq
);
    // R2: the two lines are never driven together
    a_r2_lines_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_one && out_zero));

    // R4: full and empty never hold together
    a_r4_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_full && q_empty));

    // R4: no word leaves an empty queue
    a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |-> !deq);

    // R5: a refused push sets overflow
    a_r5_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (push && q_full) |=> ovf_flag);

    // R5: overflow is sticky
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R5: a refused push with no pop leaves the queue full
    a_r5_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (push && q_full && !deq) |=> q_full);

    // R7: an accepted push clears the interrupt
    a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !q_full) |=> !tx_irq);

    // R8: push together with a pop keeps the queue non-empty
    a_r8_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !q_full && deq) |=> !q_empty);

endmodule

bind bipolar_word_tx bipolar_word_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .out_one  (out_one),
    .out_zero (out_zero),
    .q_full   (q_full),
    .q_empty  (q_empty),
    .tx_irq   (tx_irq),
    .ovf_flag (ovf_flag),
    .deq      (deq)
);

// File: tb/bipolar_word_tx_test.sv
`timescale 1ns/1ps
// Bench for bipolar_word_tx: vector table walk plus directed corner tests.
module bipolar_word_tx_test;
    localparam int HALF   = 4;
    localparam int GAPB   = 4;
    localparam int WORDCY = 32 * 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 1'b0;
    logic [31:0] push_word = '0;
    logic        odd_parity = 1'b1;
    logic        out_one, out_zero, q_full, q_empty, tx_irq, ovf_flag;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    bipolar_word_tx #(.DEPTH(5), .W(32), .HALF_CLKS(HALF), .GAP_BITS(GAPB)) uut (
        .clk(clk), .rst_n(rst_n), .push(push), .push_word(push_word),
        .odd_parity(odd_parity), .out_one(out_one), .out_zero(out_zero),
        .q_full(q_full), .q_empty(q_empty), .tx_irq(tx_irq), .ovf_flag(ovf_flag)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input logic [31:0] w, input logic odd);
        logic p;
        p = odd ? ~(^w[30:0]) : ^w[30:0];
        return {p, w[30:0]};
    endfunction

    // Line monitor: rebuilds words and checks pulse and null widths
    logic [31:0] rx_q [0:15];
    int          rx_cnt = 0;
    int          bits = 0;
    int          null_run = 0;
    int          pulse_run = 0;
    bit          prev_act = 0;
    bit          have_prev = 0;
    logic [31:0] rx_sh = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            bits = 0; null_run = 0; pulse_run = 0; prev_act = 0; have_prev = 0;
        end else begin
            if (out_one || out_zero) begin
                if (!prev_act) begin
                    if (bits == 0 && have_prev)
                        check(null_run >= GAPB * 2 * HALF, "R6 gap", null_run, GAPB * 2 * HALF);
                    else if (bits != 0)
                        check(null_run == HALF, "R2 null half", null_run, HALF);
                    rx_sh[bits] = out_one;
                    bits++;
                    if (bits == 32) begin
                        rx_q[rx_cnt % 16] = rx_sh;
                        rx_cnt++;
                        bits = 0;
                        have_prev = 1;
                    end
                    null_run = 0;
                end
                pulse_run++;
                prev_act = 1;
            end else begin
                if (prev_act) check(pulse_run == HALF, "R2 pulse width", pulse_run, HALF);
                pulse_run = 0;
                null_run++;
                prev_act = 0;
            end
        end
    end

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                finish_up();
            end
        end
    end

    task automatic wait_rx(input int target);
        int guard = 0;
        while (rx_cnt < target && guard < 4000) begin
            @(posedge clk);
            guard++;
        end
        check(rx_cnt >= target, "rx count", rx_cnt, target);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; push = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_one && !out_zero, "R1 lines", {out_one, out_zero}, 0);
        check(q_empty && !q_full, "R1 queue flags", {q_full, q_empty}, 1);
        check(!tx_irq && !ovf_flag, "R1 irq/ovf", {tx_irq, ovf_flag}, 0);
    endtask

    // Vector table: {odd_parity, word}
    localparam logic [32:0] VEC [6] = '{
        {1'b1, 32'h0000_0000}, {1'b0, 32'hFFFF_FFFF}, {1'b1, 32'h8000_00A5},
        {1'b0, 32'h1234_5678}, {1'b1, 32'h7FFF_FFFF}, {1'b0, 32'hDEAD_BEEF}
    };

    initial begin
        logic [31:0] ew;
        int base;
        do_reset();

        // Table walk: R2/R3/R9/R7 on isolated words
        for (int i = 0; i < 6; i++) begin
            ew = expect_word(VEC[i][31:0], VEC[i][32]);
            base = rx_cnt;
            @(negedge clk);
            odd_parity = VEC[i][32]; push_word = VEC[i][31:0]; push = 1'b1;
            @(negedge clk);
            push = 1'b0;
            check(!out_one && !out_zero, "R9 null one clock after push", {out_one, out_zero}, 0);
            check(!tx_irq, "R7 irq cleared by push", tx_irq, 0);
            @(negedge clk);
            check(out_one == ew[0] && out_zero == !ew[0], "R9 first bit timing", {out_one, out_zero}, {ew[0], !ew[0]});
            wait_rx(base + 1);
            check(rx_q[base % 16] == ew, "R2/R3 word content", rx_q[base % 16], ew);
            check(^rx_q[base % 16] == VEC[i][32], "R3 parity sense", ^rx_q[base % 16], VEC[i][32]);
            repeat (3 * HALF + 2) @(negedge clk);
            check(tx_irq == 1'b1, "R7 irq after last word", tx_irq, 1);
            repeat (GAPB * 2 * HALF + 4) @(negedge clk);
        end

        // Burst of seven: R8 push during pop, R4 fill to five, R5 drop the seventh
        base = rx_cnt;
        odd_parity = 1'b1;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (i == 2) check(!q_empty, "R8 push with pop accepted", q_empty, 0);
            push = 1'b1; push_word = 32'h0101_0000 + i;
        end
        @(negedge clk);
        push = 1'b0;
        check(q_full, "R4 full at five waiting", q_full, 1);
        check(ovf_flag, "R5 overflow set", ovf_flag, 1);
        wait_rx(base + 6);
        for (int i = 0; i < 6; i++)
            check(rx_q[(base + i) % 16] == expect_word(32'h0101_0000 + i, 1'b1), "R4 order",
                  rx_q[(base + i) % 16], expect_word(32'h0101_0000 + i, 1'b1));
        repeat (WORDCY + 200) @(negedge clk);
        check(rx_cnt == base + 6, "R5 dropped word not sent", rx_cnt, base + 6);
        check(ovf_flag, "R5 overflow sticky", ovf_flag, 1);
        check(q_empty, "R4 empty after drain", q_empty, 1);

        // Push in the exact cycle the last bit time ends: R7 collision
        base = rx_cnt;
        @(negedge clk); push = 1'b1; push_word = 32'h00C3_3C00;
        @(negedge clk); push = 1'b0;
        @(negedge clk);
        check(out_one || out_zero, "R9 start for collision", {out_one, out_zero}, 1);
        repeat (WORDCY - 1) @(posedge clk);
        @(negedge clk); push = 1'b1; push_word = 32'h0F0F_0F0F;
        @(negedge clk); push = 1'b0;
        check(!tx_irq, "R7 push wins over irq set", tx_irq, 0);
        check(!q_empty, "R7 collided push queued", q_empty, 0);
        wait_rx(base + 2);
        check(rx_q[(base + 1) % 16] == expect_word(32'h0F0F_0F0F, 1'b1), "R7 collided word sent",
              rx_q[(base + 1) % 16], expect_word(32'h0F0F_0F0F, 1'b1));
        repeat (3 * HALF + 2) @(negedge clk);
        check(tx_irq, "R7 irq after second word", tx_irq, 1);

        // Reset while flags are set: R1
        do_reset();
        finish_up();
    end

endmodule